// File: doc/BRIEF.md
# Stereo TDM Slot Transmit Mapper

This block forms a serial transmit frame out of one left-channel word and one right-channel word. A frame holds sixteen time slots of sixteen bits each. Software picks the slot that carries each channel. Each slot's word leaves on a single serial line, most significant bit first, one bit per bit-clock strobe. A one-bit frame-sync pulse marks the first bit of slot 0. Any slot that carries no channel sends zeros.

Software programs a control word and a data word. The control word holds a slot number for each channel, a right-channel enable and a left-repeat mode. In left-repeat mode the left word also fills the right slot, and the right data word plays no part. Both words are copied into a frame-private shadow at the first bit of every frame. A write made in the middle of a frame therefore takes effect only from the next frame. Slot number 15 means "no slot", and that channel is then never driven. When both channels name the same slot, the left channel wins.

Top module: `tdm_stereo_tx`

## Requirements
- R1: After reset, sdo, fsync and ctl_rdata are 0. The first frame after reset carries only zero bits.
- R2: A frame lasts 256 bit strobes. fsync is 1 only during the first bit of slot 0, and frames follow one another with no gap.
- R3: Control bits [11:8] give the left slot L. Data bits [31:16] give the left word. For L in 0..14, the left word goes out MSB first during slot L, at frame bit positions 16*L to 16*L+15.
- R4: Control bits [3:0] give the right slot R, and control bit 7 is the right enable. When the enable is 1 and R is in 0..14, data bits [15:0] go out MSB first during slot R.
- R5: A slot number of 15 for either channel assigns no slot, so that channel puts no bits on the line.
- R6: When control bit 7 is 0, no right-channel data is sent, whatever control bit 6 (left-repeat) holds.
- R7: When control bits 7 and 6 are both 1, the left word is sent in slot R as well, and the right data word has no effect on the line.
- R8: When both channels name the same valid slot, that slot carries the left word.
- R9: Every slot that carries neither channel sends sixteen zero bits.
- R10: Control bits [5:4] are reserved. They always read as 0 on ctl_rdata, and writes to them are ignored. The other control bits read back as written.
- R11: The control and data words are sampled at the first bit of each frame. A write made in mid-frame changes nothing in the current frame and takes effect from the next frame.
- R12: While bit_en is 0, sdo, fsync and the frame position hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-clock strobe; each high cycle advances one frame bit |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 12 | Control word to write |
| dat_wr | input | 1 | Data word write strobe |
| dat_wdata | input | 32 | Data word: left word in [31:16], right word in [15:0] |
| ctl_rdata | output | 12 | Control word readback, reserved bits as 0 |
| sdo | output | 1 | Serial transmit data |
| fsync | output | 1 | Frame-sync pulse on the first bit of slot 0 |

## Verification
The left slot is swept over all of 0..14 with the right channel disabled. This shows that each slot position is decoded on its own and that the bit order inside the slot is MSB first. The right slot is then swept in the same way while the left channel is parked on slot 15, which separates right-channel placement from the "no slot" code. Further patterns are:
- repeat with enable 0 and 1;
- repeat with two different right words;
- both channels on one slot;
- both channels parked;
- a write made in mid-frame;
- a frame sent under stalled strobes.

Each of these compares every bit of a frame against a value computed arithmetically, which tells the enable, repeat, priority, sampling-time and hold behaviours apart.

// File: rtl/tdm_pkg.sv
// Package: shared constants, control-word type and helpers for the stereo
// TDM transmit mapper. Assumes a fixed 12-bit control word with 4-bit slot
// fields; the bit layout is what the readback and write paths decode.
package tdm_pkg;
    localparam int SLOT_IDX_W = 4;
    localparam int NUM_SLOTS  = 1 << SLOT_IDX_W;
    localparam int CTL_W      = 12;
    localparam logic [SLOT_IDX_W-1:0] SLOT_NONE = '1;

    typedef struct packed {
        logic [SLOT_IDX_W-1:0] left_slot;
        logic                  right_en;
        logic                  left_rep;
        logic [SLOT_IDX_W-1:0] right_slot;
    } tx_cfg_t;

    // Build the readback image; reserved bits [5:4] are forced to zero.
    function automatic logic [CTL_W-1:0] pack_ctl(input tx_cfg_t c);
        return {c.left_slot, c.right_en, c.left_rep, 2'b00, c.right_slot};
    endfunction

    // A slot field names a real slot unless it holds the all-ones code.
    function automatic logic slot_valid(input logic [SLOT_IDX_W-1:0] s);
        return s != SLOT_NONE;
    endfunction
endpackage

// File: rtl/tdm_cfg_regs.sv
// Module: holds the software-visible control and data words.
// Assumes writes arrive as single-cycle strobes; reserved control bits are
// dropped on write so they can never read back as 1.
module tdm_cfg_regs
    import tdm_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [CTL_W-1:0]    ctl_wdata,
    input  logic                dat_wr,
    input  logic [2*WORD_W-1:0] dat_wdata,
    output tx_cfg_t             cfg,
    output logic [WORD_W-1:0]   left_word,
    output logic [WORD_W-1:0]   right_word,
    output logic [CTL_W-1:0]    ctl_rdata
);
    logic unused_rsvd_bits;
    assign unused_rsvd_bits = ^ctl_wdata[5:4];

    // Control word capture, reserved bits discarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (ctl_wr) begin
            cfg.left_slot  <= ctl_wdata[11:8];
            cfg.right_en   <= ctl_wdata[7];
            cfg.left_rep   <= ctl_wdata[6];
            cfg.right_slot <= ctl_wdata[3:0];
        end
    end

    // Data word capture: upper half left, lower half right.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_word  <= '0;
            right_word <= '0;
        end else if (dat_wr) begin
            left_word  <= dat_wdata[2*WORD_W-1:WORD_W];
            right_word <= dat_wdata[WORD_W-1:0];
        end
    end

    assign ctl_rdata = pack_ctl(cfg);
endmodule

// File: rtl/tdm_frame_counter.sv
// Module: tracks the bit position inside the frame (slot index, bit index).
// Assumes WORD_W is a power of two so the position wraps at frame end.
module tdm_frame_counter
    import tdm_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    output logic [SLOT_IDX_W-1:0] slot_idx,
    output logic                  frame_start,
    output logic                  slot_start
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam int POS_W = SLOT_IDX_W + BIT_W;

    logic [POS_W-1:0] pos;

    // Advance one frame bit per strobe; natural wrap closes the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (bit_en) begin
            pos <= pos + 1'b1;
        end
    end

    assign slot_idx    = pos[POS_W-1:BIT_W];
    assign slot_start  = (pos[BIT_W-1:0] == '0);
    assign frame_start = (pos == '0);
endmodule

// File: rtl/tdm_slot_select.sv
// Module: shadows the configuration at frame start and picks the word for
// the current slot. Assumes frame_start is high only on the frame's first
// bit; on that bit the live values are used so the shadow is never stale.
module tdm_slot_select
    import tdm_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic                  frame_start,
    input  logic [SLOT_IDX_W-1:0] slot_idx,
    input  tx_cfg_t               live_cfg,
    input  logic [WORD_W-1:0]     live_left,
    input  logic [WORD_W-1:0]     live_right,
    output logic [WORD_W-1:0]     slot_word
);
    tx_cfg_t           shd_cfg;
    logic [WORD_W-1:0] shd_left;
    logic [WORD_W-1:0] shd_right;
    tx_cfg_t           eff_cfg;
    logic [WORD_W-1:0] eff_left;
    logic [WORD_W-1:0] eff_right;
    logic [NUM_SLOTS-1:0] left_hit;
    logic [NUM_SLOTS-1:0] right_hit;
    logic              use_left;
    logic              use_right;

    // Frame-private copy of the configuration, taken on the first bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_cfg   <= '0;
            shd_left  <= '0;
            shd_right <= '0;
        end else if (bit_en && frame_start) begin
            shd_cfg   <= live_cfg;
            shd_left  <= live_left;
            shd_right <= live_right;
        end
    end

    // Values in force for the current bit.
    always_comb begin
        eff_cfg   = frame_start ? live_cfg   : shd_cfg;
        eff_left  = frame_start ? live_left  : shd_left;
        eff_right = frame_start ? live_right : shd_right;
    end

    // Per-slot match decode for each channel.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_match
        assign left_hit[s]  = slot_valid(eff_cfg.left_slot) &&
                              (eff_cfg.left_slot == SLOT_IDX_W'(s));
        assign right_hit[s] = eff_cfg.right_en &&
                              slot_valid(eff_cfg.right_slot) &&
                              (eff_cfg.right_slot == SLOT_IDX_W'(s));
    end

    // Priority pick: left first, then right (or repeated left), else zero.
    always_comb begin
        use_left  = left_hit[slot_idx];
        use_right = right_hit[slot_idx] && !use_left;
        if (use_left) begin
            slot_word = eff_left;
        end else if (use_right) begin
            slot_word = eff_cfg.left_rep ? eff_left : eff_right;
        end else begin
            slot_word = '0;
        end
    end
endmodule

// File: rtl/tdm_shifter.sv
// Module: serialises the selected word MSB first and registers frame sync.
// Assumes slot_word is valid on every bit where slot_start is high.
module tdm_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              slot_start,
    input  logic              frame_start,
    input  logic [WORD_W-1:0] slot_word,
    output logic              sdo,
    output logic              fsync
);
    logic [WORD_W-1:0] shreg;

    // Load at slot start, otherwise shift left; output leaves from the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            sdo   <= 1'b0;
            fsync <= 1'b0;
        end else if (bit_en) begin
            fsync <= frame_start;
            if (slot_start) begin
                sdo   <= slot_word[WORD_W-1];
                shreg <= {slot_word[WORD_W-2:0], 1'b0};
            end else begin
                sdo   <= shreg[WORD_W-1];
                shreg <= {shreg[WORD_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/tdm_stereo_tx.sv
// Module: top of the stereo TDM slot transmit mapper. Wires the register
// file, frame counter, slot selector and shifter. Assumes bit_en is a
// single-cycle strobe generated elsewhere from the bit clock.
module tdm_stereo_tx
    import tdm_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                ctl_wr,
    input  logic [CTL_W-1:0]    ctl_wdata,
    input  logic                dat_wr,
    input  logic [2*WORD_W-1:0] dat_wdata,
    output logic [CTL_W-1:0]    ctl_rdata,
    output logic                sdo,
    output logic                fsync
);
    tx_cfg_t               cfg;
    logic [WORD_W-1:0]     left_word;
    logic [WORD_W-1:0]     right_word;
    logic [SLOT_IDX_W-1:0] slot_idx;
    logic                  frame_start;
    logic                  slot_start;
    logic [WORD_W-1:0]     slot_word;

    tdm_cfg_regs #(.WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .cfg(cfg), .left_word(left_word), .right_word(right_word),
        .ctl_rdata(ctl_rdata)
    );

    tdm_frame_counter #(.WORD_W(WORD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .slot_idx(slot_idx), .frame_start(frame_start),
        .slot_start(slot_start)
    );

    tdm_slot_select #(.WORD_W(WORD_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .frame_start(frame_start), .slot_idx(slot_idx),
        .live_cfg(cfg), .live_left(left_word), .live_right(right_word),
        .slot_word(slot_word)
    );

    tdm_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .slot_start(slot_start), .frame_start(frame_start),
        .slot_word(slot_word), .sdo(sdo), .fsync(fsync)
    );
endmodule

// File: rtl/tdm_stereo_tx_chk.sv
// Module: assertion checker for tdm_stereo_tx, attached by bind below.
// Keeps its own frame position counter from the bit strobes it observes.
module tdm_stereo_tx_chk
    import tdm_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bit_en,
    input logic                ctl_wr,
    input logic [CTL_W-1:0]    ctl_wdata,
    input logic [CTL_W-1:0]    ctl_rdata,
    input logic                sdo,
    input logic                fsync
);
    localparam int POS_W = SLOT_IDX_W + $clog2(WORD_W);
    logic [POS_W-1:0] chk_pos;

    // Independent frame position tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_pos <= '0;
        else if (bit_en) chk_pos <= chk_pos + 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!sdo && !fsync && ctl_rdata == '0));

    p_fsync_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && chk_pos == '0) |=> fsync);

    p_fsync_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && chk_pos != '0) |=> !fsync);

    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[5:4] == 2'b00);

    p_ctl_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_rdata == ($past(ctl_wdata) & 12'hFCF)));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(sdo) && $stable(fsync)));
endmodule

bind tdm_stereo_tx tdm_stereo_tx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .sdo(sdo), .fsync(fsync)
);

// File: tb/tb_tdm_stereo_tx.sv
module tb_tdm_stereo_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [11:0] ctl_wdata = '0;
    logic        dat_wr = 1'b0;
    logic [31:0] dat_wdata = '0;
    logic [11:0] ctl_rdata;
    logic        sdo;
    logic        fsync;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    tdm_stereo_tx dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .ctl_rdata(ctl_rdata), .sdo(sdo), .fsync(fsync)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected frame bit from the requirement text: slot = pos/16, MSB first.
    function automatic logic exp_bit(input logic [11:0] c, input logic [31:0] d,
                                     input int pos);
        int slot = pos / 16;
        int b = pos % 16;
        int ls = int'(c[11:8]);
        int rs = int'(c[3:0]);
        logic [15:0] w = '0;
        if (ls != 15 && ls == slot) w = d[31:16];
        else if (c[7] && rs != 15 && rs == slot) w = c[6] ? d[31:16] : d[15:0];
        return w[15-b];
    endfunction

    task automatic wait_fs();
        do @(negedge clk); while (!fsync);
    endtask

    task automatic write_cfg(input logic [11:0] c, input logic [31:0] d);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = c; dat_wr = 1'b1; dat_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0; dat_wr = 1'b0;
    endtask

    // Called on the negedge where bit 0 of a frame is visible.
    task automatic capture(input logic [11:0] c, input logic [31:0] d,
                           input string req, input bit stall, input bit mid_wr,
                           input logic [11:0] c2, input logic [31:0] d2);
        int bad_pos = -1;
        int bad_act = 0;
        int bad_exp = 0;
        int fs_bad = -1;
        int hold_bad = 0;
        for (int i = 0; i < 256; i++) begin
            if (i > 0) @(negedge clk);
            if (mid_wr && i == 101) begin ctl_wr = 1'b0; dat_wr = 1'b0; end
            if (sdo !== exp_bit(c, d, i) && bad_pos < 0) begin
                bad_pos = i; bad_act = int'(sdo); bad_exp = int'(exp_bit(c, d, i));
            end
            if (fsync !== (i == 0) && fs_bad < 0) fs_bad = i;
            if (mid_wr && i == 100) begin
                ctl_wr = 1'b1; ctl_wdata = c2; dat_wr = 1'b1; dat_wdata = d2;
            end
            if (stall && (i % 37) == 5) begin
                logic s0 = sdo;
                logic f0 = fsync;
                bit_en = 1'b0;
                repeat (2) begin
                    @(negedge clk);
                    if (sdo !== s0 || fsync !== f0) hold_bad++;
                end
                bit_en = 1'b1;
            end
        end
        check(bad_pos < 0, req, $sformatf("frame data (first bad bit %0d)", bad_pos),
              bad_act, bad_exp);
        check(fs_bad < 0, "R2", $sformatf("fsync pattern (bad at bit %0d)", fs_bad),
              fs_bad, -1);
        if (stall) check(hold_bad == 0, "R12", "outputs held while bit_en low",
                         hold_bad, 0);
    endtask

    task automatic run_frame(input logic [11:0] c, input logic [31:0] d,
                             input string req);
        wait_fs();
        repeat (5) @(negedge clk);
        write_cfg(c, d);
        wait_fs();
        capture(c, d, req, 1'b0, 1'b0, '0, '0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (4) @(negedge clk);
        check(sdo == 1'b0, "R1", "sdo in reset", int'(sdo), 0);
        check(fsync == 1'b0, "R1", "fsync in reset", int'(fsync), 0);
        check(ctl_rdata == 12'h000, "R1", "ctl_rdata in reset", int'(ctl_rdata), 0);
        rst_n = 1'b1;
        wait_fs();
        capture(12'h000, 32'h0, "R1", 1'b0, 1'b0, '0, '0);

        // R10: reserved bits read 0, others read back
        write_cfg(12'hFFF, 32'h0);
        check(ctl_rdata == 12'hFCF, "R10", "readback of all-ones write",
              int'(ctl_rdata), 'hFCF);
        write_cfg(12'h030, 32'h0);
        check(ctl_rdata == 12'h000, "R10", "reserved-only write", int'(ctl_rdata), 0);

        // R3: left slot sweep, right disabled
        for (int ls = 0; ls < 15; ls++) begin
            logic [31:0] d = {16'h8000 | 16'(ls * 16'h0913 + 1), 16'hFFFF};
            run_frame({4'(ls), 1'b0, 1'b0, 2'b00, 4'd3}, d, "R3");
        end

        // R4: right slot sweep, left parked on slot 15 (R5)
        for (int rs = 0; rs < 15; rs++) begin
            logic [31:0] d = {16'hFFFF, 16'h8001 ^ 16'(rs * 16'h1357)};
            run_frame({4'hF, 1'b1, 1'b0, 2'b00, 4'(rs)}, d, "R4");
        end

        // R5: both channels on slot 15, enable and repeat on
        run_frame(12'hFCF, 32'hDEAD_BEEF, "R5");
        // R6: enable off, repeat on -> no right data
        run_frame({4'd2, 1'b0, 1'b1, 2'b00, 4'd7}, 32'hA5A5_3C3C, "R6");
        run_frame({4'hF, 1'b0, 1'b0, 2'b00, 4'd0}, 32'h1234_5678, "R6");
        // R7: repeat with two different right words gives the same line
        run_frame({4'd4, 1'b1, 1'b1, 2'b00, 4'd9}, 32'hC0DE_1111, "R7");
        run_frame({4'd4, 1'b1, 1'b1, 2'b00, 4'd9}, 32'hC0DE_EEEE, "R7");
        // R8: collision, left wins
        run_frame({4'd6, 1'b1, 1'b0, 2'b00, 4'd6}, 32'h9F01_7E02, "R8");
        // R9: both channels placed, everything else zero
        run_frame({4'd0, 1'b1, 1'b0, 2'b00, 4'd14}, 32'hFFFF_FFFF, "R9");

        // R11: write in mid-frame affects only the next frame
        run_frame({4'd1, 1'b1, 1'b0, 2'b00, 4'd2}, 32'hAAAA_5555, "R11");
        wait_fs();
        capture({4'd1, 1'b1, 1'b0, 2'b00, 4'd2}, 32'hAAAA_5555, "R11", 1'b0, 1'b1,
                {4'd12, 1'b1, 1'b0, 2'b00, 4'd13}, 32'h0F0F_F0F1);
        wait_fs();
        capture({4'd12, 1'b1, 1'b0, 2'b00, 4'd13}, 32'h0F0F_F0F1, "R11", 1'b0, 1'b0,
                '0, '0);

        // R12: stalled strobes during a frame
        run_frame({4'd3, 1'b1, 1'b0, 2'b00, 4'd11}, 32'hB00B_6DD6, "R12");
        wait_fs();
        capture({4'd3, 1'b1, 1'b0, 2'b00, 4'd11}, 32'hB00B_6DD6, "R12", 1'b1, 1'b0,
                '0, '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule